// File: doc/BRIEF.md
# Thermometer-Coded Digital PWM Regulator

This block closes the voltage loop of a low-voltage buck converter with purely digital logic. A single fast clock feeds an internal divider that splits time into switching periods of 64 clock slots and groups those periods sixteen at a time. An external comparator reports whether the converter output sits above or below its reference. The block takes that one-bit decision once per period and, once per group, nudges the duty setting up or down by one slot.

The duty setting lives in a 63-state thermometer register. A ring of adjacent-bit XOR gates turns the thermometer into a single active tap. That tap picks which of 63 delayed phases clears the PWM output inside the period. The output is set at the start of every period, so the duty spans 1/64 to 63/64 in steps of 1/64. The comparator and the power stage lie outside the block. The comparator arrives as an asynchronous digital input and is synchronised internally.

Top module: `thermo_pwm_reg`

## Requirements
- R1: While rst_n is low, pwm_out is 0. The divider is cleared, so the first clock edge after release is slot 0 of a new period and of a new 16-period group.
- R2: After reset the duty is 32/64, so the first period after release has pwm_out high for exactly 32 clocks.
- R3: cmp_above passes through two flip-flops and is sampled only at slot 0 of each period. The sampled value is the one present at the edge two clocks earlier (slot 62 of the previous period). Changes at any other time have no effect on the duty.
- R4: The thermometer state decodes to exactly one active tap among 63, and that tap alone sets where the pulse ends.
- R5: pwm_out goes high on the slot-0 edge of every period and low on the edge k clocks later, where k is the current duty (1..63). It is therefore high for exactly k of each 64 clocks.
- R6: The duty changes only at the last clock of each 1024-clock group (16 periods), and by at most one step. Every period inside a group has the same width.
- R7: The duty saturates at 1/64 and 63/64. Further steps toward an end leave it there, and it never wraps.
- R8: The step direction comes from the decision sampled in the last period of the group. A sampled 0 (output below reference) lengthens the duty by one slot, and a sampled 1 (above) shortens it by one slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast slot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_above | input | 1 | Asynchronous comparator result: 1 when the output is above the reference |
| pwm_out | output | 1 | Registered PWM drive for the power stage |

## Verification
A corrupted thermometer state or tap decode shows at the port within one period, as a pulse width different from the expected duty or as an output that never clears. A divider fault moves the rising edge off slot 0 at once. A fault in the direction, saturation or synchroniser path shows as a wrong width in the first period of the next group, so at most 16 periods after the stimulus. The bench compares pwm_out with a behavioural model on every clock. It also measures the width of every period, which catches each of these faults no later than that bound.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  // slot counter width: 2**SLOT_W clocks per switching period
  parameter int SLOT_W = 6;
  // group counter width: 2**GRP_W periods per duty update
  parameter int GRP_W  = 4;

  localparam int NSLOT = 1 << SLOT_W;
  localparam int NTAP  = NSLOT - 1;
  localparam int CNT_W = SLOT_W + GRP_W;
  localparam int MID   = NSLOT / 2;
endpackage

// File: rtl/tpr_divider.sv
module tpr_divider
  import tpr_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int GW = GRP_W,
  localparam int CW = SW + GW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic [SW-1:0] slot,
  output logic          per_stb,
  output logic          upd_stb
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign slot    = cnt_q[SW-1:0];
  assign per_stb = (cnt_q[SW-1:0] == '0);
  assign upd_stb = &cnt_q;
endmodule

// File: rtl/tpr_cmp_sample.sv
module tpr_cmp_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_async,
  input  logic sample_en,
  output logic decision
);
  logic meta_q, sync_q, dec_q;
  logic dec_d;

  always_comb begin
    dec_d = dec_q;
    if (sample_en) dec_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      dec_q  <= 1'b0;
    end else begin
      meta_q <= cmp_async;
      sync_q <= meta_q;
      dec_q  <= dec_d;
    end
  end

  assign decision = dec_q;
endmodule

// File: rtl/tpr_therm_reg.sv
module tpr_therm_reg
  import tpr_pkg::*;
#(
  parameter int NT = NTAP,
  parameter int MD = MID
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          go_down,
  output logic [NT-1:0] therm
);
  localparam logic [NT-1:0] MID_CODE = {{(NT-MD){1'b0}}, {MD{1'b1}}};

  logic [NT-1:0] th_q, th_d;

  always_comb begin
    th_d = th_q;
    if (step_en) begin
      if (go_down) begin
        if (th_q[1]) th_d = {1'b0, th_q[NT-1:1]};
      end else begin
        if (!th_q[NT-1]) th_d = {th_q[NT-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) th_q <= MID_CODE;
    else        th_q <= th_d;
  end

  assign therm = th_q;
endmodule

// File: rtl/tpr_tap_pwm.sv
module tpr_tap_pwm
  import tpr_pkg::*;
#(
  parameter int SW = SLOT_W,
  localparam int NT = (1 << SW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] therm,
  input  logic [SW-1:0] slot,
  input  logic          per_stb,
  output logic [NT-1:0] sel,
  output logic          pwm
);
  logic [NT-1:0] phase_hit;
  logic          clr;
  logic          pwm_q, pwm_d;

  // edge detector on the thermometer: one select per boundary
  genvar gi;
  generate
    for (gi = 0; gi < NT; gi++) begin : g_tap
      if (gi < NT - 1) begin : g_mid
        assign sel[gi] = therm[gi] ^ therm[gi+1];
      end else begin : g_top
        assign sel[gi] = therm[gi];
      end
      assign phase_hit[gi] = (slot == SW'(gi + 1));
    end
  endgenerate

  assign clr = |(sel & phase_hit);

  always_comb begin
    pwm_d = pwm_q;
    if (per_stb)  pwm_d = 1'b1;
    else if (clr) pwm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/thermo_pwm_reg.sv
module thermo_pwm_reg
  import tpr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_above,
  output logic pwm_out
);
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot;
  logic              per_stb;
  logic              upd_stb;
  logic              decision;
  logic [NTAP-1:0]   therm;
  logic [NTAP-1:0]   sel;

  tpr_divider #(.SW(SLOT_W), .GW(GRP_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt),
    .slot    (slot),
    .per_stb (per_stb),
    .upd_stb (upd_stb)
  );

  tpr_cmp_sample u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_async (cmp_above),
    .sample_en (per_stb),
    .decision  (decision)
  );

  tpr_therm_reg #(.NT(NTAP), .MD(MID)) u_therm (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (upd_stb),
    .go_down (decision),
    .therm   (therm)
  );

  tpr_tap_pwm #(.SW(SLOT_W)) u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .therm   (therm),
    .slot    (slot),
    .per_stb (per_stb),
    .sel     (sel),
    .pwm     (pwm_out)
  );
endmodule

// File: rtl/tpr_checker.sv
module tpr_checker
  import tpr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [NTAP-1:0]  therm,
  input logic [NTAP-1:0]  sel,
  input logic             pwm
);
  // R4
  a_r4_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);

  // R7: valid thermometer, never empty
  a_r7_therm_form: assert property (@(posedge clk) disable iff (!rst_n)
    therm[0] && ((therm & (therm + 1'b1)) == '0));

  // R6
  a_r6_hold_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cnt) |=> $stable(therm));

  // R8: one step at most
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt) |=> (($countones(therm) + 1 >= $past($countones(therm))) &&
                ($countones(therm) <= $past($countones(therm)) + 1)));

  // R5
  a_r5_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[SLOT_W-1:0] == '0) |=> pwm);

  // R5
  a_r5_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[SLOT_W-1:0] == SLOT_W'(NSLOT - 1)) |=> !pwm);
endmodule

bind thermo_pwm_reg tpr_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cnt   (cnt),
  .therm (therm),
  .sel   (sel),
  .pwm   (pwm_out)
);

// File: tb/tb_thermo_pwm_reg.sv
`timescale 1ns/1ps
module tb_thermo_pwm_reg;
  localparam int NS   = 64;
  localparam int FULL = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic cmp_above;
  logic pwm_out;

  int checks = 0;
  int errors = 0;

  thermo_pwm_reg dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_above (cmp_above),
    .pwm_out   (pwm_out)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  int m_cnt, m_s1, m_s2, m_dec, m_k, m_pwm, m_wrap;
  always @(posedge clk or negedge rst_n) begin
    int sl, npwm, ndec, nk;
    if (!rst_n) begin
      m_cnt = 0; m_s1 = 0; m_s2 = 0; m_dec = 0;
      m_k = NS / 2; m_pwm = 0; m_wrap = 0;
    end else begin
      sl   = m_cnt % NS;
      npwm = (sl == 0) ? 1 : ((sl == m_k) ? 0 : m_pwm);
      ndec = (sl == 0) ? m_s2 : m_dec;
      nk   = m_k;
      if (m_cnt == FULL - 1) begin
        if (m_dec != 0) nk = (m_k > 1) ? m_k - 1 : 1;
        else            nk = (m_k < NS - 1) ? m_k + 1 : NS - 1;
      end
      m_wrap = (sl == NS - 1) ? 1 : 0;
      m_s2   = m_s1;
      m_s1   = cmp_above;
      m_pwm  = npwm;
      m_dec  = ndec;
      m_k    = nk;
      m_cnt  = (m_cnt + 1) % FULL;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock trace compare and period width measurement
  int hi = 0;
  int last_w = 0;
  int periods = 0;
  always @(negedge clk) begin
    check(pwm_out == m_pwm[0], "R4 R5 cycle trace", int'(pwm_out), m_pwm);
    if (!rst_n) begin
      hi = 0;
    end else begin
      hi += int'(pwm_out);
      if (m_wrap != 0) begin
        last_w = hi;
        hi = 0;
        periods++;
      end
    end
  end

  task automatic next_period();
    int p;
    p = periods;
    while (periods == p) @(posedge clk);
  endtask

  task automatic align_group();
    while ((periods % 16) != 0) next_period();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cmp_above = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R1 output low in reset", int'(pwm_out), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // first group at mid-scale, all equal
    for (int p = 0; p < 16; p++) begin
      next_period();
      if (p == 0) check(last_w == 32, "R2 mid-scale first period", last_w, 32);
      else        check(last_w == 32, "R6 constant within group", last_w, 32);
    end
    next_period();
    check(last_w == 33, "R8 below reference lengthens", last_w, 33);

    // climb to the top and stay
    repeat (40 * 16) next_period();
    check(last_w == 63, "R7 saturate at 63", last_w, 63);

    // reverse direction
    align_group();
    cmp_above = 1'b1;
    repeat (17) next_period();
    check(last_w == 62, "R8 above reference shortens", last_w, 62);

    repeat (70 * 16) next_period();
    check(last_w == 1, "R7 saturate at 1", last_w, 1);

    // comparator low only away from the sampled point: no effect
    align_group();
    while (periods % 16 != 0 || last_w != 1) next_period();
    begin
      int tgt;
      tgt = periods + 33;
      while (periods < tgt) begin
        @(negedge clk);
        cmp_above = ((m_cnt % NS) >= 10 && (m_cnt % NS) <= 50) ? 1'b0 : 1'b1;
      end
    end
    check(last_w == 1, "R3 changes between samples ignored", last_w, 1);

    // comparator low only around the sampled point: takes effect
    align_group();
    begin
      int tgt;
      tgt = periods + 17;
      while (periods < tgt) begin
        @(negedge clk);
        cmp_above = ((m_cnt % NS) >= 60) ? 1'b0 : 1'b1;
      end
    end
    check(last_w == 2, "R3 value at sampled point used", last_w, 2);
    cmp_above = 1'b1;

    // mid-run reset
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 async reset clears output", int'(pwm_out), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    next_period();
    check(last_w == 32, "R2 mid-scale after reset", last_w, 32);
    next_period();
    check(last_w == 32, "R6 no step before group end", last_w, 32);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule